// File: doc/BRIEF.md
# Eight-Counter Event Monitor

This block gives a processor core eight 32-bit event counters. Software programs it through a small register port: two control words hold a global freeze bit, an interrupt-enable bit and one 5-bit event code per counter. The eight counters themselves sit at their own addresses and can be loaded at any time. Each clock, every counter that is not frozen adds the increment produced by its event code. That increment comes from a shared instruction-completion line, from the counter's own bank of sixteen direct event lines, from one bit of a shared four-lane byte bus, or from a pairwise sum over one byte lane.

A counter that carries out of its top bit sets a sticky overflow flag. The registered interrupt output is the OR of all flags, gated by the interrupt enable. Loading a counter clears its flag. A load in the same cycle as an increment wins over the increment. Reads return the addressed register one cycle after the address is presented.

Top module: `perf_mon_unit`

## Requirements
- R1: After synchronous reset, control word 0 reads 0x80000810: freeze set, interrupt enable clear, counter 1 and counter 2 codes 0x08. Control word 1 reads 0x42108420: every code 0x08, all adder enables clear. Every counter reads 0, and `irq_o` is 0.
- R2: The register map is: address 0 is control word 0 and address 1 is control word 1, both 64-bit and read back as written. Addresses 2 to 9 are counters 1 to 8, zero-extended on read. Other addresses read 0. `reg_rdata` shows the addressed value as it stood at the clock edge that samples `reg_addr`.
- R3: The event code for counter 1 is control word 0 bits [12:8], and for counter 2 it is bits [5:1]. Counter n (3 to 8) uses control word 1 bits starting at 5*(8-n)+2, so counter 3 is at [31:27] and counter 8 is at [6:2].
- R4: While control word 0 bit 31 (freeze) is set, no counter changes except by a register load.
- R5: Code 0x08 holds a counter. Code 0x00 also holds it when that counter's adder enable is clear.
- R6: On any counter, code 0x0F adds 1 every cycle, and code 0x09 adds 1 in each cycle that `inst_done` is high.
- R7: Codes 0x01 to 0x07 and 0x0A to 0x0E add `dir_evt[16*(n-1)+code]` for counter n.
- R8: Codes with bit 4 set add one bit of the byte bus: lane L, bit `code[2:0]`, where lane L occupies `lane_bus[8L+7:8L]`. Counters 1, 2, 5 and 6 use lane 0 when code bit 3 is 0 and lane 2 when it is 1. Counters 3, 4, 7 and 8 use lane 1 or lane 3 in the same way.
- R9: Code 0x00 with the counter's adder enable set adds (b0+b4)+(b1+b5)+(b2+b6)+(b3+b7) of the counter's lower lane. Counter n's adder enable is control word 1 bit 40-n, so counter 1 is bit 39 and counter 8 is bit 32.
- R10: A counter that wraps past 0xFFFFFFFF keeps its carried-out value and sets a sticky overflow flag. Only a load of that counter clears the flag.
- R11: `irq_o` is registered. It is 1 in the cycle after any overflow flag is set while control word 0 bit 30 (interrupt enable) is 1, and it is 0 otherwise.
- R12: A counter load in a cycle where the counter would also increment leaves exactly the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data for `reg_addr` |
| inst_done | input | 1 | Instruction-completion event, shared by all counters |
| dir_evt | input | 128 | Sixteen direct event lines per counter |
| lane_bus | input | 32 | Four byte lanes of shared bus events |
| irq_o | output | 1 | Registered overflow interrupt |

## Verification
The bench targets several corner cases:
- Irregular select offsets: one counter at a time is set counting while the other seven hold. A misplaced field makes the wrong counter move.
- Lane pairing: all eight counters take bus codes together under random bus traffic. Swapping the lower and upper lane, or the two counter groups, shows up as wrong counts.
- Adder mode: it runs next to code-0 counters that have the enable clear. A design that sums the wrong bit pairs drifts, and one that lets plain code 0 count moves a counter that should hold.
- Overflow: a counter is wrapped with the interrupt disabled, the interrupt is then enabled, and the counter is reloaded. A non-sticky flag, an ungated interrupt or a load that keeps the flag each fail.
- Load priority: a load that collides with counting must leave the loaded value plus only the later increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_W      = 64;
  localparam int unsigned SEL_W      = 5;
  localparam int unsigned FRZ_BIT    = 31;
  localparam int unsigned IE_BIT     = 30;
  localparam int unsigned ADD_EN_TOP = 39;

  localparam logic [SEL_W-1:0] CODE_NONE = 5'h00;
  localparam logic [SEL_W-1:0] CODE_HOLD = 5'h08;
  localparam logic [SEL_W-1:0] CODE_INST = 5'h09;
  localparam logic [SEL_W-1:0] CODE_CYC  = 5'h0F;

  // Low bit of a counter's code field; counters 0,1 live in word 0, rest in word 1
  function automatic int unsigned sel_lsb(input int unsigned idx);
    if (idx == 0) return 8;
    if (idx == 1) return 1;
    return 5 * (7 - idx) + 2;
  endfunction

  function automatic logic [REG_W-1:0] ctrl0_rst();
    logic [REG_W-1:0] v;
    v = '0;
    v[FRZ_BIT] = 1'b1;
    v[sel_lsb(0) +: SEL_W] = CODE_HOLD;
    v[sel_lsb(1) +: SEL_W] = CODE_HOLD;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] ctrl1_rst(input int unsigned n_ctr);
    logic [REG_W-1:0] v;
    v = '0;
    for (int unsigned i = 2; i < n_ctr; i++) v[sel_lsb(i) +: SEL_W] = CODE_HOLD;
    return v;
  endfunction
endpackage

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we0,
  input  logic                       we1,
  input  logic [REG_W-1:0]           wdata,
  output logic [REG_W-1:0]           ctrl0_o,
  output logic [REG_W-1:0]           ctrl1_o,
  output logic                       frz_o,
  output logic                       ie_o,
  output logic [NUM_CTR*SEL_W-1:0]   sel_o,
  output logic [NUM_CTR-1:0]         add_en_o
);
  logic [REG_W-1:0] ctrl0_q, ctrl1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0_q <= ctrl0_rst();
      ctrl1_q <= ctrl1_rst(NUM_CTR);
    end else begin
      if (we0) ctrl0_q <= wdata;
      if (we1) ctrl1_q <= wdata;
    end
  end

  assign ctrl0_o = ctrl0_q;
  assign ctrl1_o = ctrl1_q;
  assign frz_o   = ctrl0_q[FRZ_BIT];
  assign ie_o    = ctrl0_q[IE_BIT];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_field
    localparam int unsigned LSB = sel_lsb(i);
    if (i < 2) begin : g_word0
      assign sel_o[i*SEL_W +: SEL_W] = ctrl0_q[LSB +: SEL_W];
    end else begin : g_word1
      assign sel_o[i*SEL_W +: SEL_W] = ctrl1_q[LSB +: SEL_W];
    end
    assign add_en_o[i] = ctrl1_q[ADD_EN_TOP - i];
  end
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
  import pmu_pkg::*;
#(
  parameter int unsigned IDX       = 0,
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned DIR_W     = 16,
  parameter int unsigned INC_W     = 4
) (
  input  logic [SEL_W-1:0]            code,
  input  logic                        add_en,
  input  logic                        inst_done,
  input  logic [DIR_W-1:0]            dir_evt,
  input  logic [NUM_LANES*LANE_W-1:0] lanes,
  output logic [INC_W-1:0]            inc
);
  localparam int unsigned LANE_LO = (IDX / 2) % 2;
  localparam int unsigned LANE_HI = LANE_LO + 2;
  localparam int unsigned HALF    = LANE_W / 2;

  logic [LANE_W-1:0] lo_lane, hi_lane, pick_lane;
  logic [INC_W-1:0]  pair_sum;

  assign lo_lane   = lanes[LANE_LO*LANE_W +: LANE_W];
  assign hi_lane   = lanes[LANE_HI*LANE_W +: LANE_W];
  assign pick_lane = code[3] ? hi_lane : lo_lane;

  always_comb begin
    pair_sum = '0;
    for (int k = 0; k < HALF; k++)
      pair_sum = pair_sum + INC_W'(lo_lane[k]) + INC_W'(lo_lane[k+HALF]);
  end

  always_comb begin
    inc = '0;
    if (code[4])                inc = INC_W'(pick_lane[code[2:0]]);
    else if (code == CODE_NONE) inc = add_en ? pair_sum : '0;
    else if (code == CODE_HOLD) inc = '0;
    else if (code == CODE_CYC)  inc = INC_W'(1);
    else if (code == CODE_INST) inc = INC_W'(inst_done);
    else                        inc = INC_W'(dir_evt[code[3:0]]);
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned CTR_W = 32,
  parameter int unsigned INC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frz,
  input  logic             we,
  input  logic [CTR_W-1:0] wdata,
  input  logic [INC_W-1:0] inc,
  output logic [CTR_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CTR_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CTR_W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{(CTR_W+1-INC_W){1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (we) begin
      cnt_q <= wdata;
      ovf_q <= 1'b0;
    end else if (!frz) begin
      cnt_q <= sum[CTR_W-1:0];
      if (sum[CTR_W]) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CTR   = 8,
  parameter int unsigned CTR_W     = 32,
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned DIR_W     = 16,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic                        inst_done,
  input  logic [NUM_CTR*DIR_W-1:0]    dir_evt,
  input  logic [NUM_LANES*LANE_W-1:0] lane_bus,
  output logic                        irq_o
);
  localparam int unsigned INC_W    = $clog2(LANE_W + 1);
  localparam int unsigned CTR_BASE = 2;

  logic [REG_W-1:0]         ctrl0, ctrl1;
  logic                     frz_q, ie_q;
  logic [NUM_CTR*SEL_W-1:0] sel_flat;
  logic [NUM_CTR-1:0]       add_en, ctr_we, ovf;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic [CTR_W-1:0]         cnt [NUM_CTR];
  logic                     irq_q;

  pmu_ctrl_regs #(.NUM_CTR(NUM_CTR)) u_regs (
    .clk(clk), .rst(rst),
    .we0(reg_we && reg_addr == ADDR_W'(0)),
    .we1(reg_we && reg_addr == ADDR_W'(1)),
    .wdata(reg_wdata),
    .ctrl0_o(ctrl0), .ctrl1_o(ctrl1),
    .frz_o(frz_q), .ie_o(ie_q),
    .sel_o(sel_flat), .add_en_o(add_en)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [INC_W-1:0] inc;

    assign ctr_we[i] = reg_we && reg_addr == ADDR_W'(i + CTR_BASE);

    pmu_evt_sel #(
      .IDX(i), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W),
      .DIR_W(DIR_W), .INC_W(INC_W)
    ) u_sel (
      .code(sel_flat[i*SEL_W +: SEL_W]),
      .add_en(add_en[i]),
      .inst_done(inst_done),
      .dir_evt(dir_evt[i*DIR_W +: DIR_W]),
      .lanes(lane_bus),
      .inc(inc)
    );

    pmu_counter #(.CTR_W(CTR_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst(rst), .frz(frz_q),
      .we(ctr_we[i]), .wdata(reg_wdata[CTR_W-1:0]),
      .inc(inc), .cnt_o(cnt[i]), .ovf_o(ovf[i])
    );

    assign cnt_flat[i*CTR_W +: CTR_W] = cnt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= (|ovf) & ie_q;
      if (reg_addr == ADDR_W'(0))      reg_rdata <= ctrl0;
      else if (reg_addr == ADDR_W'(1)) reg_rdata <= ctrl1;
      else begin
        reg_rdata <= '0;
        for (int i = 0; i < NUM_CTR; i++)
          if (reg_addr == ADDR_W'(i + CTR_BASE)) reg_rdata <= REG_W'(cnt[i]);
      end
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CTR_W   = 32,
  parameter int unsigned REG_W   = 64,
  parameter int unsigned SEL_W   = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic [REG_W-1:0]         reg_wdata,
  input logic                     frz,
  input logic                     ie,
  input logic                     irq_o,
  input logic [NUM_CTR-1:0]       ovf,
  input logic [NUM_CTR-1:0]       ctr_we,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
  input logic [NUM_CTR*SEL_W-1:0] sel_flat
);
  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (frz && !(|ctr_we)) |=> $stable(cnt_flat));

  a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq_o);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (|(ovf & ~ctr_we)) |=> ((ovf & $past(ovf & ~ctr_we)) == $past(ovf & ~ctr_we)));

  a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
    ctr_we[0] |=> (cnt_flat[CTR_W-1:0] == $past(reg_wdata[CTR_W-1:0]) && !ovf[0]));

  a_r5_hold_code: assert property (@(posedge clk) disable iff (rst)
    (sel_flat[SEL_W-1:0] == 5'h08 && !ctr_we[0]) |=> $stable(cnt_flat[CTR_W-1:0]));
endmodule

bind perf_mon_unit pmu_chk #(
  .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .REG_W(pmu_pkg::REG_W), .SEL_W(pmu_pkg::SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wdata(reg_wdata),
  .frz(frz_q), .ie(ie_q), .irq_o(irq_o),
  .ovf(ovf), .ctr_we(ctr_we), .cnt_flat(cnt_flat), .sel_flat(sel_flat)
);

// File: tb/perf_mon_unit_tb.sv
module perf_mon_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic         inst_done = 1'b0;
  logic [127:0] dir_evt = '0;
  logic [31:0]  lane_bus = '0;
  logic         irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_mon_unit u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inst_done(inst_done),
    .dir_evt(dir_evt), .lane_bus(lane_bus), .irq_o(irq_o)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0]     m_c0, m_c1, m_rd;
  longint unsigned m_cnt [8];
  bit              m_ovf [8];
  bit              m_irq;

  function automatic int code_of(int n);
    if (n == 0) return int'(m_c0[12:8]);
    if (n == 1) return int'(m_c0[5:1]);
    return int'((m_c1 >> (37 - 5*n)) & 64'h1F);
  endfunction

  function automatic int step_of(int n);
    int c, lane, s;
    c = code_of(n);
    case (n)
      2, 3, 6, 7: lane = 1;
      default:    lane = 0;
    endcase
    if (c >= 16) begin
      if (c & 8) lane += 2;
      return int'(lane_bus[lane*8 + (c & 7)]);
    end
    if (c == 0) begin
      if (!m_c1[39-n]) return 0;
      s = 0;
      for (int k = 0; k < 4; k++)
        s += int'(lane_bus[lane*8+k]) + int'(lane_bus[lane*8+k+4]);
      return s;
    end
    if (c == 8)  return 0;
    if (c == 15) return 1;
    if (c == 9)  return int'(inst_done);
    return int'(dir_evt[n*16 + c]);
  endfunction

  always @(posedge clk) begin
    int st [8];
    if (rst) begin
      m_c0 = 64'h8000_0810;
      m_c1 = 64'h4210_8420;
      for (int n = 0; n < 8; n++) begin m_cnt[n] = 0; m_ovf[n] = 0; end
      m_rd = 0; m_irq = 0;
    end else begin
      if (reg_addr == 0)      m_rd = m_c0;
      else if (reg_addr == 1) m_rd = m_c1;
      else if (reg_addr <= 9) m_rd = 64'(m_cnt[reg_addr-2]);
      else                    m_rd = 0;
      m_irq = 0;
      for (int n = 0; n < 8; n++) if (m_ovf[n] && m_c0[30]) m_irq = 1;
      for (int n = 0; n < 8; n++) st[n] = step_of(n);
      for (int n = 0; n < 8; n++) begin
        if (reg_we && reg_addr == 4'(n+2)) begin
          m_cnt[n] = longint'(reg_wdata[31:0]);
          m_ovf[n] = 0;
        end else if (!m_c0[31]) begin
          m_cnt[n] = m_cnt[n] + longint'(st[n]);
          if (m_cnt[n] > 64'hFFFF_FFFF) begin
            m_ovf[n] = 1;
            m_cnt[n] = m_cnt[n] & 64'hFFFF_FFFF;
          end
        end
      end
      if (reg_we && reg_addr == 0) m_c0 = reg_wdata;
      if (reg_we && reg_addr == 1) m_c1 = reg_wdata;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 readback vs model", reg_rdata, m_rd);
      check("R11 irq vs model", 64'(irq_o), 64'(m_irq));
    end
  end

  // random event stimulus, driven away from the active edge
  always @(negedge clk) begin
    inst_done <= 1'($urandom);
    dir_evt   <= {$urandom, $urandom, $urandom, $urandom};
    lane_bus  <= $urandom;
  end

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, m_rd);
  endtask

  task automatic rd_exp(input logic [3:0] a, input string tag, input logic [63:0] e);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, e);
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 8; i++) rd(4'(i+2), tag);
  endtask

  function automatic logic [63:0] mk0(input bit f, input bit ie,
                                      input logic [4:0] s1, input logic [4:0] s2);
    return {32'b0, f, ie, 17'b0, s1, 2'b0, s2, 1'b0};
  endfunction

  function automatic logic [63:0] mk1(input logic [4:0] s3, s4, s5, s6, s7, s8,
                                      input logic [7:0] add);
    return {24'b0, add, s3, s4, s5, s6, s7, s8, 2'b0};
  endfunction

  initial begin
    logic [4:0] s [8];
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_exp(0, "R1 ctrl0 reset", 64'h8000_0810);
    rd_exp(1, "R1 ctrl1 reset", 64'h4210_8420);
    for (int i = 0; i < 8; i++) rd_exp(4'(i+2), "R1 counter reset", 64'h0);
    check("R1 irq reset", 64'(irq_o), 64'h0);

    // R2 register access
    wr(1, 64'h0000_0055_AAAA_5554);
    rd_exp(1, "R2 ctrl1 readback", 64'h0000_0055_AAAA_5554);
    wr(1, 64'h4210_8420);
    wr(4, 64'hFFFF_FFFF_0000_1234);
    rd_exp(4, "R2 counter load truncates", 64'h0000_1234);
    rd_exp(4'd12, "R2 unmapped reads zero", 64'h0);

    // R4 freeze: every counter selects cycle count, but frozen
    wr(1, mk1(5'h0F, 5'h0F, 5'h0F, 5'h0F, 5'h0F, 5'h0F, 8'h00));
    wr(0, mk0(1, 0, 5'h0F, 5'h0F));
    repeat (20) @(negedge clk);
    for (int i = 0; i < 8; i++)
      rd_exp(4'(i+2), "R4 frozen counter", (i == 2) ? 64'h1234 : 64'h0);

    // R3 one counter at a time
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) s[i] = (i == k) ? 5'h0F : 5'h08;
      wr(1, mk1(s[2], s[3], s[4], s[5], s[6], s[7], 8'h00));
      wr(0, mk0(0, 0, s[0], s[1]));
      repeat (5) @(negedge clk);
      wr(0, mk0(1, 0, s[0], s[1]));
      rd_all("R3 field position");
    end

    // R6 cycle and instruction codes
    wr(1, mk1(5'h09, 5'h0F, 5'h09, 5'h0F, 5'h09, 5'h0F, 8'h00));
    wr(0, mk0(0, 0, 5'h0F, 5'h09));
    repeat (40) @(negedge clk);
    wr(0, mk0(1, 0, 5'h0F, 5'h09));
    rd_all("R6 cycle/instr count");

    // R7 direct lines
    wr(1, mk1(5'h03, 5'h04, 5'h05, 5'h0A, 5'h0B, 5'h0E, 8'h00));
    wr(0, mk0(0, 0, 5'h01, 5'h07));
    repeat (40) @(negedge clk);
    wr(0, mk0(1, 0, 5'h01, 5'h07));
    rd_all("R7 direct events");

    // R8 bus bits, both lanes of each pair
    wr(1, mk1(5'h1A, 5'h13, 5'h15, 5'h1E, 5'h17, 5'h18, 8'h00));
    wr(0, mk0(0, 0, 5'h11, 5'h1C));
    repeat (40) @(negedge clk);
    wr(0, mk0(1, 0, 5'h11, 5'h1C));
    rd_all("R8 bus lane bit");

    // R9 adder on counters 1,3,5,7; R5 code 0 without adder and 0x08 hold
    wr(1, mk1(5'h00, 5'h00, 5'h00, 5'h08, 5'h00, 5'h00, 8'b1010_1010));
    wr(0, mk0(0, 0, 5'h00, 5'h00));
    repeat (40) @(negedge clk);
    wr(0, mk0(1, 0, 5'h00, 5'h00));
    for (int i = 0; i < 8; i++)
      rd(4'(i+2), (i % 2 == 0) ? "R9 adder mode" : "R5 hold codes");

    // R10/R11 overflow with interrupt disabled, then enabled, then cleared
    wr(6, 64'hFFFF_FFF0);
    wr(1, mk1(5'h08, 5'h08, 5'h0F, 5'h08, 5'h08, 5'h08, 8'h00));
    wr(0, mk0(0, 0, 5'h08, 5'h08));
    repeat (30) @(negedge clk);
    check("R11 irq gated off", 64'(irq_o), 64'h0);
    rd(6, "R10 wrapped value");
    wr(0, mk0(0, 1, 5'h08, 5'h08));
    repeat (2) @(negedge clk);
    check("R11 irq raised on enable", 64'(irq_o), 64'h1);
    wr(6, 64'h5);
    repeat (2) @(negedge clk);
    check("R10 load clears overflow", 64'(irq_o), 64'h0);

    // R12 load collides with counting
    wr(6, 64'h77);
    wr(0, mk0(1, 1, 5'h08, 5'h08));
    rd_exp(6, "R12 load wins over increment", 64'h78);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule